// File: doc/BRIEF.md
# Per-Region Memory Wait-State Controller

This controller sits between one bus master and four memory regions and produces only the timing of each access. It does not hold any data. The master presents a request strobe together with a direction, a region code and a burst flag. The controller then raises a read-data-valid pulse or a write-accept pulse once the addressed region's latency has passed. While it waits, it holds a busy line high so that the master stalls. The four regions are:

- a register region, fast in both directions;
- an SRAM region, where reads are slower than writes;
- an EEPROM region, where reads are slower still and bursts run at half rate;
- an external region, whose read and write cycle counts come from two configuration inputs.

A request is taken on a rising clock edge at which `req_i` is high and `busy_o` is low. An access of latency N has these cycles after that edge:

- `busy_o` is high for the first N-1 cycles;
- the completion pulse is high in the Nth cycle;
- `busy_o` is low in the pulse cycle, so a new request can be taken on the edge that ends it.

A read burst continues beat by beat for as long as the burst flag stays high. Its first beat has the single-read latency. Later beats follow at the region's beat interval.

Top module: `memwait_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy_o`, `rvalid_o` and `wack_o` are all low. An access in flight when reset is asserted produces no pulse, either during reset or after it.
- R2: Region code 0 (register region) completes a read or a write with latency 1. With `req_i` held high, the controller takes a new request on every cycle and gives one pulse per cycle.
- R3: Region code 1 (SRAM) has a write latency of 1 and a single-read latency of 2.
- R4: Region code 2 (EEPROM) has a write latency of 1 and a single-read latency of 3.
- R5: Region code 3 (external) has a read latency of `ext_rd_cyc_i` and a write latency of `ext_wr_cyc_i`. Both are sampled when the request is taken, and a value of 0 gives a latency of 1.
- R6: A read burst to SRAM (`burst_i`=1 when the request is taken) delivers its first beat at latency 2, then one beat on every following cycle.
- R7: A read burst to EEPROM delivers its first beat at latency 3, then one beat every second cycle. A read burst to the external region repeats its beats every `ext_rd_cyc_i` cycles.
- R8: The burst flag is sampled on the edge that produces each beat. If it is low there, that beat is the last one and `busy_o` is low in its cycle. Lowering the flag in the cycle of beat m-1 therefore gives exactly m beats.
- R9: A request made while `busy_o` is high is ignored. It produces no pulse and does not change the pending access.
- R10: A read (`we_i`=0) completes only with `rvalid_o` and a write (`we_i`=1) only with `wack_o`. Each pulse lasts one cycle, and the two are never high together.
- R11: Writes ignore `burst_i`. A write always gives one `wack_o` pulse, with `busy_o` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| region_i | input | 2 | Region code: 0 register, 1 SRAM, 2 EEPROM, 3 external |
| burst_i | input | 1 | Burst flag; requests or continues a read burst |
| ext_rd_cyc_i | input | CFG_W | External read cycle count (0 treated as 1) |
| ext_wr_cyc_i | input | CFG_W | External write cycle count (0 treated as 1) |
| busy_o | output | 1 | Stall: an access is pending |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| wack_o | output | 1 | One-cycle write accept pulse |

## Verification
A table of single accesses covers every region in both directions, and the external region with counts of 0, 1 and a maximum of 15. This separates the fixed latencies from one another and shows the zero-as-one rule. Different read and write counts on the external region show that each direction uses its own setting.

Bursts of different lengths on SRAM, EEPROM and the external region measure the first-beat latency, the spacing between beats and the beat count. Together these tell the three beat intervals apart and confirm where a burst ends. Further directed patterns cover back-to-back register writes, a request made during an EEPROM read, writes with the burst flag high, and reset in the middle of an external access.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

    typedef enum logic [1:0] {
        RGN_IO     = 2'd0,
        RGN_SRAM   = 2'd1,
        RGN_EEPROM = 2'd2,
        RGN_EXT    = 2'd3
    } region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    // Context of the access currently held by the controller
    typedef struct packed {
        logic is_wr;
        logic brst;
    } ctx_s;

    // Fixed latencies (cycles) and read burst beat intervals
    localparam int IO_LAT      = 1;
    localparam int SRAM_RD_LAT = 2;
    localparam int SRAM_WR_LAT = 1;
    localparam int EE_RD_LAT   = 3;
    localparam int EE_WR_LAT   = 1;
    localparam int IO_GAP      = 1;
    localparam int SRAM_GAP    = 1;
    localparam int EE_GAP      = 2;

endpackage

// File: rtl/memwait_lut.sv
module memwait_lut
    import memwait_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  region_e              rgn,
    input  logic                 is_wr,
    input  logic [CFG_W-1:0]     ext_rd_cfg,
    input  logic [CFG_W-1:0]     ext_wr_cfg,
    output logic [CFG_W-1:0]     lat,
    output logic [CFG_W-1:0]     gap
);
    localparam int NCFG = 2;

    logic [CFG_W-1:0] cfg_raw [NCFG];
    logic [CFG_W-1:0] cfg_eff [NCFG];

    assign cfg_raw[0] = ext_rd_cfg;
    assign cfg_raw[1] = ext_wr_cfg;

    // A programmed count of zero behaves as a single cycle
    for (genvar i = 0; i < NCFG; i++) begin : g_clamp
        assign cfg_eff[i] = (cfg_raw[i] == '0) ? CFG_W'(1) : cfg_raw[i];
    end

    always_comb begin
        lat = CFG_W'(IO_LAT);
        gap = CFG_W'(IO_GAP);
        case (rgn)
            RGN_IO: begin
                lat = CFG_W'(IO_LAT);
                gap = CFG_W'(IO_GAP);
            end
            RGN_SRAM: begin
                lat = is_wr ? CFG_W'(SRAM_WR_LAT) : CFG_W'(SRAM_RD_LAT);
                gap = CFG_W'(SRAM_GAP);
            end
            RGN_EEPROM: begin
                lat = is_wr ? CFG_W'(EE_WR_LAT) : CFG_W'(EE_RD_LAT);
                gap = CFG_W'(EE_GAP);
            end
            RGN_EXT: begin
                lat = is_wr ? cfg_eff[1] : cfg_eff[0];
                gap = cfg_eff[0];
            end
            default: begin
                lat = CFG_W'(IO_LAT);
                gap = CFG_W'(IO_GAP);
            end
        endcase
    end

endmodule

// File: rtl/memwait_cnt.sv
module memwait_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
    import memwait_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [1:0]       region_i,
    input  logic             burst_i,
    input  logic [CFG_W-1:0] ext_rd_cyc_i,
    input  logic [CFG_W-1:0] ext_wr_cyc_i,
    output logic             busy_o,
    output logic             rvalid_o,
    output logic             wack_o
);
    localparam int CNT_W = CFG_W;

    region_e          rgn;
    logic [CNT_W-1:0] acc_lat;
    logic [CNT_W-1:0] acc_gap;

    state_e           state_q, state_d;
    ctx_s             ctx_q, ctx_d;
    logic [CNT_W-1:0] gap_q, gap_d;
    logic             rvalid_q, wack_q;

    logic             accept;
    logic             fire;
    logic             fire_wr;
    logic             cont;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    assign rgn = region_e'(region_i);

    memwait_lut #(
        .CFG_W (CFG_W)
    ) u_lut (
        .rgn        (rgn),
        .is_wr      (we_i),
        .ext_rd_cfg (ext_rd_cyc_i),
        .ext_wr_cfg (ext_wr_cyc_i),
        .lat        (acc_lat),
        .gap        (acc_gap)
    );

    memwait_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        accept   = req_i && (state_q == ST_IDLE);
        fire     = 1'b0;
        fire_wr  = 1'b0;
        cont     = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        state_d  = state_q;
        ctx_d    = ctx_q;
        gap_d    = gap_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    ctx_d.is_wr = we_i;
                    ctx_d.brst  = burst_i && !we_i;
                    gap_d       = acc_gap;
                    if (acc_lat == CNT_W'(1)) begin
                        // Completes on this edge; may open a burst
                        fire    = 1'b1;
                        fire_wr = we_i;
                        cont    = ctx_d.brst;
                        if (cont) begin
                            state_d  = ST_WAIT;
                            cnt_load = 1'b1;
                            cnt_val  = acc_gap - CNT_W'(1);
                        end
                    end else begin
                        state_d  = ST_WAIT;
                        cnt_load = 1'b1;
                        cnt_val  = acc_lat - CNT_W'(2);
                    end
                end
            end
            ST_WAIT: begin
                if (cnt_zero) begin
                    fire    = 1'b1;
                    fire_wr = ctx_q.is_wr;
                    cont    = ctx_q.brst && burst_i;
                    if (cont) begin
                        cnt_load = 1'b1;
                        cnt_val  = gap_q - CNT_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctx_q    <= '0;
            gap_q    <= '0;
            rvalid_q <= 1'b0;
            wack_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            ctx_q    <= ctx_d;
            gap_q    <= gap_d;
            rvalid_q <= fire && !fire_wr;
            wack_q   <= fire && fire_wr;
        end
    end

    assign busy_o   = (state_q == ST_WAIT);
    assign rvalid_o = rvalid_q;
    assign wack_o   = wack_q;

endmodule

// File: rtl/memwait_chk.sv
module memwait_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic       we_i,
    input logic [1:0] region_i,
    input logic       busy_o,
    input logic       rvalid_o,
    input logic       wack_o
);
    // R1: outputs quiet in the cycle after a reset edge
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !rvalid_o && !wack_o));

    // R10: never both completion kinds at once
    a_r10_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(rvalid_o && wack_o));

    // R2: register region answers on the next cycle
    a_r2_io_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_i && !busy_o && region_i == 2'd0) |=> (rvalid_o || wack_o));

    // R3: SRAM write accepted next cycle without stalling
    a_r3_sram_write: assert property (@(posedge clk) disable iff (rst)
        (req_i && !busy_o && region_i == 2'd1 && we_i) |=> (wack_o && !busy_o));

    // R4: EEPROM read stalls two cycles then returns data
    a_r4_ee_read: assert property (@(posedge clk) disable iff (rst)
        (req_i && !busy_o && region_i == 2'd2 && !we_i)
        |=> (busy_o && !rvalid_o) ##1 (busy_o && !rvalid_o) ##1 rvalid_o);

    // R11: a write accept always ends the access
    a_r11_write_ends: assert property (@(posedge clk) disable iff (rst)
        wack_o |-> !busy_o);

endmodule

bind memwait_ctrl memwait_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .we_i     (we_i),
    .region_i (region_i),
    .busy_o   (busy_o),
    .rvalid_o (rvalid_o),
    .wack_o   (wack_o)
);

// File: tb/memwait_ctrl_tb.sv
`timescale 1ns/1ps
module memwait_ctrl_tb;
    localparam int CFG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             we = 1'b0;
    logic [1:0]       region = 2'd0;
    logic             burst = 1'b0;
    logic [CFG_W-1:0] rd_cfg = '0;
    logic [CFG_W-1:0] wr_cfg = '0;
    logic             busy, rvalid, wack;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    memwait_ctrl #(.CFG_W(CFG_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .we_i         (we),
        .region_i     (region),
        .burst_i      (burst),
        .ext_rd_cyc_i (rd_cfg),
        .ext_wr_cyc_i (wr_cfg),
        .busy_o       (busy),
        .rvalid_o     (rvalid),
        .wack_o       (wack)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Single access; returns latency and whether the wrong pulse kind appeared
    task automatic run_single(input logic w, input logic [1:0] g,
                              output int got, output int wrong);
        @(negedge clk);
        req = 1'b1; we = w; region = g; burst = 1'b0;
        @(negedge clk);
        req = 1'b0;
        got = 0; wrong = 0;
        for (int c = 1; c <= 40; c++) begin
            if (rvalid || wack) begin
                got = c;
                wrong = w ? int'(rvalid || !wack) : int'(wack || !rvalid);
                break;
            end
            @(negedge clk);
        end
    endtask

    // Read burst of m beats; checks first latency L and beat interval G
    task automatic run_burst(input logic [1:0] g, input int m, input int L,
                             input int G, input string tag);
        int beats, last, first, badgap, wrongk;
        @(negedge clk);
        req = 1'b1; we = 1'b0; region = g; burst = 1'b1;
        @(negedge clk);
        req = 1'b0;
        beats = 0; last = 0; first = 0; badgap = 0; wrongk = 0;
        for (int c = 1; c <= 60; c++) begin
            if (wack) wrongk++;
            if (rvalid) begin
                beats++;
                if (beats == 1) first = c;
                else if (c - last != G) badgap = c - last;
                last = c;
                if (beats == m - 1) burst = 1'b0;
            end
            @(negedge clk);
        end
        burst = 1'b0;
        check(first == L, {tag, " first beat latency"}, first, L);
        check(badgap == 0, {tag, " beat interval"}, badgap, G);
        check(beats == m, {tag, " R8 beat count"}, beats, m);
        check(wrongk == 0 && !busy, {tag, " R10 no write pulse, idle after"}, wrongk, 0);
    endtask

    // Vector: {req tag, we, region, ext cfg (rd and wr), expected latency}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {4'd2, 1'b0, 2'd0, 4'd0,  5'd1},   // R2 register read
        {4'd2, 1'b1, 2'd0, 4'd9,  5'd1},   // R2 register write
        {4'd3, 1'b1, 2'd1, 4'd0,  5'd1},   // R3 SRAM write
        {4'd3, 1'b0, 2'd1, 4'd0,  5'd2},   // R3 SRAM read
        {4'd4, 1'b1, 2'd2, 4'd0,  5'd1},   // R4 EEPROM write
        {4'd4, 1'b0, 2'd2, 4'd8,  5'd3},   // R4 EEPROM read
        {4'd5, 1'b0, 2'd3, 4'd5,  5'd5},   // R5 external read
        {4'd5, 1'b1, 2'd3, 4'd7,  5'd7},   // R5 external write
        {4'd5, 1'b0, 2'd3, 4'd0,  5'd1},   // R5 zero read count
        {4'd5, 1'b1, 2'd3, 4'd0,  5'd1},   // R5 zero write count
        {4'd5, 1'b0, 2'd3, 4'd15, 5'd15},  // R5 largest count
        {4'd5, 1'b1, 2'd3, 4'd1,  5'd1}    // R5 count of one
    };

    initial begin
        int got, wrong, cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !rvalid && !wack, "R1 outputs low in reset", int'({busy, rvalid, wack}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rvalid && !wack, "R1 outputs low after reset", int'({busy, rvalid, wack}), 0);

        for (int i = 0; i < NV; i++) begin
            rd_cfg = VEC[i][8:5];
            wr_cfg = VEC[i][8:5];
            run_single(VEC[i][11], VEC[i][10:9], got, wrong);
            check(got == int'(VEC[i][4:0]) && wrong == 0,
                  $sformatf("R%0d vector %0d latency/kind", VEC[i][15:12], i),
                  got, int'(VEC[i][4:0]));
        end

        // R5: read and write counts are independent
        rd_cfg = 4'd3; wr_cfg = 4'd9;
        run_single(1'b0, 2'd3, got, wrong);
        check(got == 3 && wrong == 0, "R5 external read uses read count", got, 3);
        run_single(1'b1, 2'd3, got, wrong);
        check(got == 9 && wrong == 0, "R5 external write uses write count", got, 9);

        // R2: back-to-back register writes, one pulse per cycle
        @(negedge clk);
        req = 1'b1; we = 1'b1; region = 2'd0;
        @(negedge clk);
        check(wack && !busy, "R2 first back-to-back accept", int'(wack), 1);
        @(negedge clk);
        req = 1'b0;
        check(wack && !busy, "R2 second back-to-back accept", int'(wack), 1);
        @(negedge clk);
        check(!wack && !rvalid, "R2 no pulse after request drops", int'(wack), 0);

        // R6 / R7 / R8: bursts
        run_burst(2'd1, 4, 2, 1, "R6 SRAM burst");
        run_burst(2'd2, 3, 3, 2, "R7 EEPROM burst");
        rd_cfg = 4'd3;
        run_burst(2'd3, 3, 3, 3, "R7 external burst");
        run_burst(2'd1, 2, 2, 1, "R8 short SRAM burst");

        // R9: requests while busy are ignored
        @(negedge clk);
        req = 1'b1; we = 1'b0; region = 2'd2; burst = 1'b0;
        @(negedge clk);
        we = 1'b1; region = 2'd0;            // stays requesting while busy
        cnt = 0;
        for (int c = 1; c <= 2; c++) begin
            if (wack || rvalid) cnt++;
            @(negedge clk);
        end
        req = 1'b0;
        check(rvalid && !wack, "R9 pending EEPROM read completes unchanged", int'({rvalid, wack}), 2);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (wack || rvalid) cnt++;
        end
        check(cnt == 0, "R9 ignored request gave no pulse", cnt, 0);

        // R11: writes ignore burst flag
        for (int r = 1; r <= 2; r++) begin
            @(negedge clk);
            req = 1'b1; we = 1'b1; region = 2'(r); burst = 1'b1;
            @(negedge clk);
            req = 1'b0;
            check(wack && !busy, $sformatf("R11 write region %0d single accept", r), int'({wack, busy}), 2);
            cnt = 0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                if (wack || rvalid || busy) cnt++;
            end
            burst = 1'b0;
            check(cnt == 0, $sformatf("R11 write region %0d no further beats", r), cnt, 0);
        end

        // R1: reset in the middle of an external read
        rd_cfg = 4'd10;
        @(negedge clk);
        req = 1'b1; we = 1'b0; region = 2'd3;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !rvalid && !wack, "R1 reset aborts access", int'({busy, rvalid, wack}), 0);
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (wack || rvalid || busy) cnt++;
        end
        check(cnt == 0, "R1 no pulse after aborted access", cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule